// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional Branching

This block is the address-generation heart of a horizontally microcoded control unit. It keeps a microprogram counter, a single-entry return register and a constant control store of wide microwords. Each microword holds control bits for the datapath, an 8-bit binary jump target, a 4-bit condition selector, a 2-bit address-source selector and a call flag. A 16:1 test multiplexer picks one external condition. When the chosen condition is true, the source selector decides the next address. When it is false, the sequencer steps to the following address.

The microword for the next address is read from the store and captured in a pipeline register on every active edge. The control outputs therefore remain steady for a whole cycle while the following word is being looked up. Opcode dispatch lands on microaddresses 0 to 15. Because address 0 belongs to opcode 0, reset enters at microaddress 18. A low ready input freezes the step, so a slow memory can stretch it.

Top module: `useq_core`

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it falls, `uaddr_o` is 18 and `ctrl_o` is the control field of the word at 18. The return register also resets to 18.
- R2: `ctrl_o` always carries the control field of the microword at `uaddr_o`, changing on the same edge. In the shipped microprogram, the word at address a has the control field {~a, a}.
- R3: The 4-bit condition selector picks `cond_i[sel]`. Selector value 15 is treated as always true, and `cond_i[15]` has no effect.
- R4: When the selected condition is false, the next address is `uaddr_o + 1`, whatever the source selector says. Source code 00 also yields `uaddr_o + 1`.
- R5: Source code 01 with a true condition loads the microword's 8-bit next-address field.
- R6: Source code 10 with a true condition loads the opcode `op_i`, zero-extended, so opcode n lands on microaddress n.
- R7: A word whose call flag is set and whose condition is true writes `uaddr_o + 1` into the return register in the same cycle as the jump. Source code 11 with a true condition loads the return register.
- R8: While `ready_i` is low, `uaddr_o`, `ctrl_o` and the return register keep their values.
- R9: The shipped microprogram is laid out as follows.
  - Address 18 steps to 19, and 19 dispatches on the opcode.
  - Each slot a in 0..15 jumps to 0x40 when condition a is true. Otherwise it falls through to a+1.
  - 0x40 calls 0x60. 0x60 steps to 0x61, which returns. 0x41 jumps back to 19.
  - Every other address jumps to 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Instruction opcode used by dispatch |
| cond_i | input | 16 | External test conditions (bit 15 unused) |
| ready_i | input | 1 | Step enable; low holds the current step |
| uaddr_o | output | 8 | Current microaddress |
| ctrl_o | output | 16 | Registered control-signal field of the current microword |

## Verification
Several rules are checked by assertions on every cycle:
- the fall-through to the next address on a false test;
- dispatch to the opcode and return to the saved address;
- the return-register write on a call;
- the freeze while ready is low;
- the low half of the control field following the address.

The layout of the microprogram, the always-true slot ignoring its input, and complete call-and-return traces are shown only by the bench's scenarios. Those scenarios cover all sixteen opcodes, a long not-taken chain, stalls, a reset mid-run and a pseudo-random stretch, and each cycle is compared with a behavioural model.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [1:0] {
      SRC_SEQ    = 2'b00,
      SRC_JUMP   = 2'b01,
      SRC_DISP   = 2'b10,
      SRC_RETURN = 2'b11
   } src_e;

   localparam int DEF_ADDR_W  = 8;
   localparam int DEF_CTRL_W  = 16;
   localparam int DEF_COND_N  = 16;
   localparam int DEF_OPC_W   = 4;
   localparam int DEF_ENTRY   = 18;

endpackage

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
#(
   parameter int ADDR_W = DEF_ADDR_W,
   parameter int CTRL_W = DEF_CTRL_W,
   parameter int CSEL_W = 4,
   parameter int ENTRY  = DEF_ENTRY,
   localparam int DEPTH = 1 << ADDR_W,
   localparam int W     = CTRL_W + 1 + 2 + CSEL_W + ADDR_W
) (
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [W-1:0]      rd_word
);

   localparam int NXT_LSB  = 0;
   localparam int CSEL_LSB = NXT_LSB + ADDR_W;
   localparam int SRC_LSB  = CSEL_LSB + CSEL_W;
   localparam int CALL_BIT = SRC_LSB + 2;
   localparam int CTRL_LSB = CALL_BIT + 1;
   localparam int ALWAYS   = (1 << CSEL_W) - 1;
   localparam int DISP_AT  = ENTRY + 1;
   localparam int CALL_AT  = 'h40;
   localparam int RESUME   = 'h41;
   localparam int SUB_AT   = 'h60;
   localparam int SUB_RET  = 'h61;

   function automatic logic [W-1:0] build_word(input int a);
      logic [W-1:0]      w;
      logic [ADDR_W-1:0] av;
      int                nx;
      int                cs;
      logic [1:0]        sr;
      logic              cl;
      av = ADDR_W'(a);
      nx = ENTRY;
      cs = ALWAYS;
      sr = SRC_JUMP;
      cl = 1'b0;
      if (a == ENTRY) begin
         sr = SRC_SEQ;
      end else if (a == DISP_AT) begin
         sr = SRC_DISP;
      end else if (a < 16) begin
         cs = a;
         nx = CALL_AT;
      end else if (a == CALL_AT) begin
         nx = SUB_AT;
         cl = 1'b1;
      end else if (a == RESUME) begin
         nx = DISP_AT;
      end else if (a == SUB_AT) begin
         sr = SRC_SEQ;
      end else if (a == SUB_RET) begin
         sr = SRC_RETURN;
      end
      w = '0;
      w[NXT_LSB +: ADDR_W]  = ADDR_W'(nx);
      w[CSEL_LSB +: CSEL_W] = CSEL_W'(cs);
      w[SRC_LSB +: 2]       = sr;
      w[CALL_BIT]           = cl;
      for (int i = 0; i < CTRL_W; i++) begin
         w[CTRL_LSB + i] = av[i % ADDR_W] ^ (((i / ADDR_W) % 2) == 1);
      end
      return w;
   endfunction

   logic [W-1:0] rom [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_rom
      assign rom[a] = build_word(a);
   end

   assign rd_word = rom[rd_addr];

endmodule

// File: rtl/useq_test_mux.sv
module useq_test_mux #(
   parameter int COND_N  = 16,
   parameter bit TRUE_EN = 1'b1,
   localparam int CSEL_W = $clog2(COND_N)
) (
   input  logic [COND_N-1:0] cond,
   input  logic [CSEL_W-1:0] sel,
   output logic              hit
);

   localparam logic [CSEL_W-1:0] TRUE_SEL = CSEL_W'(COND_N - 1);

   if (TRUE_EN) begin : g_true_slot
      assign hit = (sel == TRUE_SEL) ? 1'b1 : cond[sel];
   end else begin : g_plain
      assign hit = cond[sel];
   end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
   import useq_pkg::*;
#(
   parameter int ADDR_W = DEF_ADDR_W,
   parameter int OPC_W  = DEF_OPC_W
) (
   input  logic [ADDR_W-1:0] upc,
   input  logic [ADDR_W-1:0] jump_tgt,
   input  logic [ADDR_W-1:0] ret_addr,
   input  logic [OPC_W-1:0]  opcode,
   input  src_e              src,
   input  logic              hit,
   output logic [ADDR_W-1:0] incr,
   output logic [ADDR_W-1:0] nxt
);

   assign incr = upc + 1'b1;

   always_comb begin
      nxt = incr;
      if (hit) begin
         unique case (src)
            SRC_SEQ:    nxt = incr;
            SRC_JUMP:   nxt = jump_tgt;
            SRC_DISP:   nxt = ADDR_W'(opcode);
            SRC_RETURN: nxt = ret_addr;
            default:    nxt = incr;
         endcase
      end
   end

endmodule

// File: rtl/useq_core.sv
module useq_core
   import useq_pkg::*;
#(
   parameter int ADDR_W = DEF_ADDR_W,
   parameter int CTRL_W = DEF_CTRL_W,
   parameter int COND_N = DEF_COND_N,
   parameter int OPC_W  = DEF_OPC_W,
   parameter int ENTRY  = DEF_ENTRY
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [OPC_W-1:0]  op_i,
   input  logic [COND_N-1:0] cond_i,
   input  logic              ready_i,
   output logic [ADDR_W-1:0] uaddr_o,
   output logic [CTRL_W-1:0] ctrl_o
);

   localparam int CSEL_W   = $clog2(COND_N);
   localparam int W        = CTRL_W + 1 + 2 + CSEL_W + ADDR_W;
   localparam int NXT_LSB  = 0;
   localparam int CSEL_LSB = NXT_LSB + ADDR_W;
   localparam int SRC_LSB  = CSEL_LSB + CSEL_W;
   localparam int CALL_BIT = SRC_LSB + 2;
   localparam int CTRL_LSB = CALL_BIT + 1;
   localparam logic [ADDR_W-1:0] ENTRY_A = ADDR_W'(ENTRY);

   initial begin
      if (ADDR_W < 7 || OPC_W > ADDR_W || CTRL_W < ADDR_W || ENTRY < 16 ||
          ENTRY + 1 >= (1 << ADDR_W) || COND_N != (1 << CSEL_W))
         $fatal(1, "useq_core: unsupported parameter set");
   end

   logic [ADDR_W-1:0] upc_q, ret_q, nxt, incr, rd_addr;
   logic [W-1:0]      word_q, rd_word;
   logic              hit;
   src_e              src;

   assign src = src_e'(word_q[SRC_LSB +: 2]);

   useq_test_mux #(.COND_N(COND_N), .TRUE_EN(1'b1)) u_tmux (
      .cond (cond_i),
      .sel  (word_q[CSEL_LSB +: CSEL_W]),
      .hit  (hit)
   );

   useq_next_addr #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_nxt (
      .upc      (upc_q),
      .jump_tgt (word_q[NXT_LSB +: ADDR_W]),
      .ret_addr (ret_q),
      .opcode   (op_i),
      .src      (src),
      .hit      (hit),
      .incr     (incr),
      .nxt      (nxt)
   );

   assign rd_addr = rst_i ? ENTRY_A : nxt;

   useq_store #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .CSEL_W(CSEL_W), .ENTRY(ENTRY)) u_store (
      .rd_addr (rd_addr),
      .rd_word (rd_word)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         upc_q  <= ENTRY_A;
         word_q <= rd_word;
         ret_q  <= ENTRY_A;
      end else if (ready_i) begin
         upc_q  <= nxt;
         word_q <= rd_word;
         if (word_q[CALL_BIT] && hit)
            ret_q <= incr;
      end
   end

   assign uaddr_o = upc_q;
   assign ctrl_o  = word_q[CTRL_LSB +: CTRL_W];

endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
   parameter int ADDR_W = 8,
   parameter int CTRL_W = 16,
   parameter int OPC_W  = 4,
   parameter int ENTRY  = 18
) (
   input logic              clk,
   input logic              rst,
   input logic              ready,
   input logic [OPC_W-1:0]  opcode,
   input logic [ADDR_W-1:0] upc,
   input logic [CTRL_W-1:0] ctrl,
   input logic [ADDR_W-1:0] ret,
   input logic              hit,
   input logic [1:0]        src,
   input logic              call
);

   assert_reset_entry_R1: assert property (@(posedge clk)
      rst |=> (upc == ADDR_W'(ENTRY)));

   assert_ctrl_tracks_R2: assert property (@(posedge clk) disable iff (rst)
      ctrl[ADDR_W-1:0] == upc);

   assert_fallthrough_R4: assert property (@(posedge clk) disable iff (rst)
      (ready && !hit) |=> (upc == ADDR_W'($past(upc) + 1'b1)));

   assert_dispatch_R6: assert property (@(posedge clk) disable iff (rst)
      (ready && hit && src == 2'b10) |=> (upc == ADDR_W'($past(opcode))));

   assert_call_save_R7: assert property (@(posedge clk) disable iff (rst)
      (ready && hit && call) |=> (ret == ADDR_W'($past(upc) + 1'b1)));

   assert_return_R7: assert property (@(posedge clk) disable iff (rst)
      (ready && hit && src == 2'b11) |=> (upc == $past(ret)));

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !ready |=> ($stable(upc) && $stable(ctrl) && $stable(ret)));

endmodule

bind useq_core useq_checker #(
   .ADDR_W (ADDR_W),
   .CTRL_W (CTRL_W),
   .OPC_W  (OPC_W),
   .ENTRY  (ENTRY)
) u_chk (
   .clk    (clk_i),
   .rst    (rst_i),
   .ready  (ready_i),
   .opcode (op_i),
   .upc    (upc_q),
   .ctrl   (ctrl_o),
   .ret    (ret_q),
   .hit    (hit),
   .src    (word_q[SRC_LSB +: 2]),
   .call   (word_q[CALL_BIT])
);

// File: tb/useq_core_bench.sv
module useq_core_bench;

   logic        clk_i = 1'b0;
   logic        rst_i = 1'b1;
   logic [3:0]  op_i = '0;
   logic [15:0] cond_i = '0;
   logic        ready_i = 1'b0;
   logic [7:0]  uaddr_o;
   logic [15:0] ctrl_o;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;
   int    m_addr = 18;
   int    m_ret = 18;
   string m_tag = "R1";

   always #5 clk_i = ~clk_i;

   useq_core u_useq_core (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .op_i    (op_i),
      .cond_i  (cond_i),
      .ready_i (ready_i),
      .uaddr_o (uaddr_o),
      .ctrl_o  (ctrl_o)
   );

   // R9: behavioural view of the shipped microprogram
   task automatic prog(input int a, output int src, output int cs, output int nx, output bit call);
      src = 1; cs = 15; nx = 18; call = 0;
      if (a == 18)        src = 0;
      else if (a == 19)   src = 2;
      else if (a < 16)    begin cs = a; nx = 'h40; end
      else if (a == 'h40) begin nx = 'h60; call = 1; end
      else if (a == 'h41) nx = 19;
      else if (a == 'h60) src = 0;
      else if (a == 'h61) src = 3;
   endtask

   task automatic compare();
      logic [15:0] exp_ctrl;
      exp_ctrl = {~8'(m_addr), 8'(m_addr)};
      n_cmp++;
      if (uaddr_o !== 8'(m_addr)) begin
         n_bad++;
         $display("FAIL %s/R9 uaddr actual=%0h expected=%0h", m_tag, uaddr_o, m_addr);
      end
      n_cmp++;
      if (ctrl_o !== exp_ctrl) begin
         n_bad++;
         $display("FAIL R2 ctrl actual=%0h expected=%0h", ctrl_o, exp_ctrl);
      end
   endtask

   // Apply inputs at a falling edge, advance the model, compare at the next falling edge
   task automatic cyc(input logic [3:0] op, input logic [15:0] c, input logic r, input logic rs);
      int  src, cs, nx;
      bit  call, hit;
      op_i = op; cond_i = c; ready_i = r; rst_i = rs;
      if (rs) begin
         m_addr = 18; m_ret = 18; m_tag = "R1";
      end else if (!r) begin
         m_tag = "R8";
      end else begin
         prog(m_addr, src, cs, nx, call);
         hit = (cs == 15) ? 1'b1 : c[cs];
         if (!hit) begin
            m_tag = "R4";
            m_addr = (m_addr + 1) % 256;
         end else begin
            m_tag = (cs == 15 && !c[15]) ? "R3" : "R5";
            if (call) m_ret = (m_addr + 1) % 256;
            case (src)
               0: begin m_addr = (m_addr + 1) % 256; m_tag = "R4"; end
               1: m_addr = nx;
               2: begin m_addr = op; m_tag = "R6"; end
               default: begin m_addr = m_ret; m_tag = "R7"; end
            endcase
         end
      end
      @(negedge clk_i);
      compare();
   endtask

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk_i);
      compare();                                   // R1 reset state
      cyc(4'd0, 16'hffff, 1'b1, 1'b0);             // R1 first cycle after reset: 18 -> 19
      for (int op = 0; op < 16; op++)              // R6 dispatch of each opcode, R7 call/return
         repeat (6) cyc(4'(op), 16'hffff, 1'b1, 1'b0);
      repeat (24) cyc(4'd3, 16'h0000, 1'b1, 1'b0); // R4 not-taken chain, R3 slot 15 with cond 15 low
      repeat (4) cyc(4'd7, 16'h0080, 1'b1, 1'b0);
      repeat (3) cyc(4'd7, 16'hffff, 1'b0, 1'b0);  // R8 stall
      repeat (4) cyc(4'd7, 16'h0080, 1'b1, 1'b0);
      repeat (2) cyc(4'd7, 16'h0080, 1'b0, 1'b0);  // R8 stall inside subroutine
      repeat (6) cyc(4'd7, 16'h0080, 1'b1, 1'b0);
      repeat (2) cyc(4'd2, 16'hffff, 1'b1, 1'b1);  // R1 reset mid-run
      cyc(4'd15, 16'h0000, 1'b1, 1'b0);
      repeat (8) cyc(4'd15, 16'h0000, 1'b1, 1'b0); // R3 cond 15 ignored at slot 15
      lfsr = 16'hace1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[3:0], {lfsr[7:0], lfsr[15:8]}, (lfsr[5:4] != 2'b00), 1'b0);
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule